// File: doc/BRIEF.md
# Multi-Port FIFO Access Arbiter

This block sits between one datapath and a set of word-wide FIFO ports on a common clock. Some ports are inbound (the datapath reads words out of them) and some are outbound (the datapath writes words into them); a parameter mask fixes which is which. Each port raises a request, and its FIFO reports an empty flag (inbound) or a full flag (outbound). The arbiter grants one port at a time and issues a per-port strobe on every cycle in which a word actually moves on the granted port. The strobe serves as the read enable on an inbound FIFO and the write enable on an outbound one.

When the grant passes from one port to another, the arbiter inserts one dead cycle in which no port is granted and no word moves. Two policies are available. Rotate lets each granted port move at most one word before the grant passes to the next requester, which halves aggregate throughput when several ports contend. Hold leaves the grant on a port for as long as it keeps requesting and keeps moving words, so a long burst runs at one word per cycle. A granted port that its FIFO flag blocks gives up the grant whenever another port is waiting. This keeps one stalled stream from starving the others.

Top module: `fifo_port_arbiter`

## Requirements
- R1: `grant_o` has at most one bit set in every cycle, and `xfer_o` is only ever set on the granted port.
- R2: With one port requesting and its FIFO always ready, the grant appears in the cycle after the request is first seen from idle, and a word then moves on every following cycle with no dead cycle.
- R3: When the grant moves to a different port, there is exactly one cycle with `dead_o`=1, `grant_o`=0 and no strobe. The new port is granted in the next cycle.
- R4: With `policy_i`=0 (rotate), a granted port keeps the grant for one cycle only while any other port requests. The next owner is the first requesting port after the current one in ascending cyclic index order. With all ports requesting and ready, exactly one word moves every two cycles.
- R5: With `policy_i`=1 (hold), the grant stays on a port as long as its request is high and a word moved in the previous cycle. With all ports requesting and ready, a word moves on every cycle after the first grant.
- R6: An outbound port (its `OUT_MASK` bit is 1) is never strobed while its `full_i` bit is 1, and its `empty_i` bit has no effect.
- R7: An inbound port (its `OUT_MASK` bit is 0) is never strobed while its `empty_i` bit is 1, and its `full_i` bit has no effect.
- R8: A granted port that moved no word in a cycle while another port requests loses the grant: the next cycle is a dead cycle.
- R9: `policy_i` is sampled only in idle cycles (no grant and no dead cycle). A change while a port holds the grant has no effect until the arbiter next goes idle.
- R10: `dp_rd_valid_o` is 1 exactly when an inbound port is strobed, and `dp_rd_data_o` then equals that port's slice of `fifo_rd_data_i` (port p at bits p*DATA_W upward). `dp_wr_take_o` is 1 exactly when an outbound port is strobed.
- R11: During and right after reset, `grant_o`, `xfer_o` and `dead_o` are 0. The first grant after reset searches from port 0.
- R12: If the granted port drops its request and no other port requests, the grant is released in the next cycle without a dead cycle. A grant taken from idle takes no dead cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports and the datapath |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 1 | 0 = rotate, 1 = hold; sampled only when idle |
| req_i | input | N_PORTS | Per-port transfer request |
| empty_i | input | N_PORTS | Empty flag of each inbound FIFO |
| full_i | input | N_PORTS | Full flag of each outbound FIFO |
| fifo_rd_data_i | input | N_PORTS*DATA_W | Head word of every FIFO, port p in slice p |
| grant_o | output | N_PORTS | One-hot grant |
| xfer_o | output | N_PORTS | Per-port word strobe (read or write enable) |
| dead_o | output | 1 | High in a turnaround cycle |
| dp_rd_data_o | output | DATA_W | Word read from the granted inbound port |
| dp_rd_valid_o | output | 1 | A word is being read this cycle |
| dp_wr_take_o | output | 1 | The datapath's outgoing word is written this cycle |

## Verification
The bench first drives a lone requester, which shows whether the arbiter streams without dead cycles. It then drives every port requesting under rotate, where a count of exactly one word per two cycles separates correct turnaround from a missing or doubled dead cycle. Under hold with the same pattern, only a one-word-per-cycle count is accepted. That hold burst also flips `policy_i` mid-grant, which exposes sampling of the policy outside idle. Long stretches of seeded random stimulus follow, with sticky requests, varying density and random empty and full flags. Each cycle is compared against a bench model built from the requirements. These stretches reach blocked owners, release to idle and cyclic pointer wrap-around, and catch wrong successor choice, strobes on blocked ports and read data taken from the wrong slice.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

   typedef enum logic {
      POL_ROTATE = 1'b0,
      POL_HOLD   = 1'b1
   } fpa_policy_e;

endpackage

// File: rtl/fpa_rr_pick.sv
// Cyclic first-one finder: scans mask_i starting at index start_i and
// wrapping around, returns the first set position.
module fpa_rr_pick #(
   parameter int unsigned N  = 4,
   parameter int unsigned IW = 2
) (
   input  logic [N-1:0]  mask_i,
   input  logic [IW-1:0] start_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int k = 0; k < int'(N); k++) begin
         int p;
         p = (int'(start_i) + k) % int'(N);
         if (!found_o && mask_i[p]) begin
            found_o = 1'b1;
            idx_o   = IW'(p);
         end
      end
   end

endmodule

// File: rtl/fpa_port_qual.sv
// Per-port readiness: outbound ports are ready when not full, inbound
// ports when not empty. A strobe needs grant, request and readiness.
module fpa_port_qual #(
   parameter int unsigned          N        = 4,
   parameter logic [N-1:0]         OUT_MASK = '0
) (
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] grant_i,
   input  logic [N-1:0] empty_i,
   input  logic [N-1:0] full_i,
   output logic [N-1:0] ready_o,
   output logic [N-1:0] xfer_o
);

   for (genvar p = 0; p < int'(N); p++) begin : g_port
      if (OUT_MASK[p]) begin : g_out
         logic unused_empty;
         assign unused_empty = empty_i[p];
         assign ready_o[p]   = ~full_i[p];
      end else begin : g_in
         logic unused_full;
         assign unused_full = full_i[p];
         assign ready_o[p]  = ~empty_i[p];
      end
      assign xfer_o[p] = grant_i[p] & req_i[p] & ready_o[p];
   end

endmodule

// File: rtl/fpa_rd_mux.sv
// Selects the head word of the owning port for the datapath read side.
module fpa_rd_mux #(
   parameter int unsigned N      = 4,
   parameter int unsigned IW     = 2,
   parameter int unsigned DATA_W = 32
) (
   input  logic [N*DATA_W-1:0] data_i,
   input  logic [IW-1:0]       sel_i,
   output logic [DATA_W-1:0]   data_o
);

   logic [DATA_W-1:0] slice [N];

   for (genvar p = 0; p < int'(N); p++) begin : g_slice
      assign slice[p] = data_i[p*DATA_W +: DATA_W];
   end

   always_comb begin
      data_o = '0;
      for (int p = 0; p < int'(N); p++) begin
         if (sel_i == IW'(p)) data_o = slice[p];
      end
   end

endmodule

// File: rtl/fifo_port_arbiter.sv
module fifo_port_arbiter
   import fpa_pkg::*;
#(
   parameter int unsigned          N_PORTS  = 4,
   parameter int unsigned          DATA_W   = 32,
   parameter logic [N_PORTS-1:0]   OUT_MASK = 4'b1100
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        policy_i,
   input  logic [N_PORTS-1:0]          req_i,
   input  logic [N_PORTS-1:0]          empty_i,
   input  logic [N_PORTS-1:0]          full_i,
   input  logic [N_PORTS*DATA_W-1:0]   fifo_rd_data_i,
   output logic [N_PORTS-1:0]          grant_o,
   output logic [N_PORTS-1:0]          xfer_o,
   output logic                        dead_o,
   output logic [DATA_W-1:0]           dp_rd_data_o,
   output logic                        dp_rd_valid_o,
   output logic                        dp_wr_take_o
);

   localparam int unsigned IW = $clog2(N_PORTS);
   localparam logic [IW-1:0] LAST_IDX = IW'(N_PORTS - 1);
   localparam logic [N_PORTS-1:0] ONE = N_PORTS'(1);

   if (N_PORTS < 2 || N_PORTS > 32) begin : g_bad_ports
      $error("fifo_port_arbiter: N_PORTS must lie in 2..32");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("fifo_port_arbiter: DATA_W must be at least 1");
   end

   // ---------------- state ----------------
   logic [IW-1:0] owner_q, owner_d;
   logic          owned_q, owned_d;
   logic          dead_q,  dead_d;
   fpa_policy_e   pol_q,   pol_d;

   logic                active;
   logic [N_PORTS-1:0]  ready;
   logic [N_PORTS-1:0]  others;
   logic [N_PORTS-1:0]  pick_mask;
   logic [IW-1:0]       scan_start;
   logic                pick_found;
   logic [IW-1:0]       pick_idx;
   logic                own_req;
   logic                own_xfer;

   assign active  = owned_q & ~dead_q;
   assign grant_o = active ? (ONE << owner_q) : '0;
   assign dead_o  = dead_q;

   fpa_port_qual #(
      .N        (N_PORTS),
      .OUT_MASK (OUT_MASK)
   ) u_qual (
      .req_i   (req_i),
      .grant_i (grant_o),
      .empty_i (empty_i),
      .full_i  (full_i),
      .ready_o (ready),
      .xfer_o  (xfer_o)
   );

   // Search starts one past the last owner; while owning, the owner is
   // masked out so the successor is always a different port.
   assign scan_start = (owner_q == LAST_IDX) ? '0 : owner_q + IW'(1);
   assign others     = req_i & ~(ONE << owner_q);
   assign pick_mask  = owned_q ? others : req_i;

   fpa_rr_pick #(
      .N  (N_PORTS),
      .IW (IW)
   ) u_pick (
      .mask_i  (pick_mask),
      .start_i (scan_start),
      .found_o (pick_found),
      .idx_o   (pick_idx)
   );

   assign own_req  = req_i[owner_q];
   assign own_xfer = xfer_o[owner_q];

   always_comb begin
      owner_d = owner_q;
      owned_d = owned_q;
      dead_d  = 1'b0;
      pol_d   = pol_q;
      if (dead_q) begin
         dead_d = 1'b0;
      end else if (owned_q) begin
         if (|others && (pol_q == POL_ROTATE || !own_xfer)) begin
            owner_d = pick_idx;
            dead_d  = 1'b1;
         end else if (!own_req) begin
            owned_d = 1'b0;
         end
      end else begin
         pol_d = fpa_policy_e'(policy_i);
         if (pick_found) begin
            owner_d = pick_idx;
            owned_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_q <= LAST_IDX;
         owned_q <= 1'b0;
         dead_q  <= 1'b0;
         pol_q   <= POL_ROTATE;
      end else begin
         owner_q <= owner_d;
         owned_q <= owned_d;
         dead_q  <= dead_d;
         pol_q   <= pol_d;
      end
   end

   // ---------------- datapath side ----------------
   fpa_rd_mux #(
      .N      (N_PORTS),
      .IW     (IW),
      .DATA_W (DATA_W)
   ) u_mux (
      .data_i (fifo_rd_data_i),
      .sel_i  (owner_q),
      .data_o (dp_rd_data_o)
   );

   assign dp_rd_valid_o = |(xfer_o & ~OUT_MASK);
   assign dp_wr_take_o  = |(xfer_o & OUT_MASK);

   // ---------------- assertions ----------------
   a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o) && ((xfer_o & ~grant_o) == '0));

   a_r3_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      dead_o |-> (grant_o == '0) && (xfer_o == '0));

   a_r3_dead_once: assert property (@(posedge clk) disable iff (!rst_n)
      dead_o |=> !dead_o && $onehot(grant_o));

   a_r3_no_back_to_back_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (|$past(xfer_o)) && (|xfer_o) |-> xfer_o == $past(xfer_o));

   a_r4_rotate_yields: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_q == POL_ROTATE) && (|grant_o) && (|(req_i & ~grant_o)) |=> dead_o);

   a_r5_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_q == POL_HOLD) && (|xfer_o) |=> grant_o == $past(grant_o));

   a_r6_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_o & OUT_MASK & full_i) == '0);

   a_r7_no_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_o & ~OUT_MASK & empty_i) == '0);

   a_r8_blocked_yields: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_o) && (xfer_o == '0) && (|(req_i & ~grant_o)) |=> dead_o);

   a_r9_policy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (owned_q || dead_q) |=> $stable(pol_q));

   a_r12_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_o) && ((req_i & grant_o) == '0) && ((req_i & ~grant_o) == '0)
      |=> (grant_o == '0) && !dead_o);

endmodule

// File: tb/fifo_port_arbiter_bench.sv
module fifo_port_arbiter_bench;

   localparam int N = 4;
   localparam int W = 32;
   localparam logic [N-1:0] OUTM = 4'b1100;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             policy = 1'b0;
   logic [N-1:0]     req = '0, empty = '0, full = '0;
   logic [N*W-1:0]   rdata = '0;
   logic [N-1:0]     grant, xfer;
   logic             dead, rd_valid, wr_take;
   logic [W-1:0]     rd_data;

   always #4 clk = ~clk;

   fifo_port_arbiter #(.N_PORTS(N), .DATA_W(W), .OUT_MASK(OUTM)) u_fifo_port_arbiter (
      .clk(clk), .rst_n(rst_n), .policy_i(policy), .req_i(req),
      .empty_i(empty), .full_i(full), .fifo_rd_data_i(rdata),
      .grant_o(grant), .xfer_o(xfer), .dead_o(dead),
      .dp_rd_data_o(rd_data), .dp_rd_valid_o(rd_valid), .dp_wr_take_o(wr_take));

   int n_chk = 0, n_fail = 0, moved = 0;
   bit done = 1'b0;

   // reference state
   int m_owner = N - 1;
   bit m_owned = 0, m_dead = 0, m_pol = 0;

   task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
      end
   endtask

   function automatic int first_from(input logic [N-1:0] m, input int start);
      for (int k = 0; k < N; k++) begin
         if (m[(start + k) % N]) return (start + k) % N;
      end
      return -1;
   endfunction

   task automatic step(input logic pol, input logic [N-1:0] rq, input logic [N-1:0] em, input logic [N-1:0] fu);
      logic [N-1:0] g_e, rdy, x_e, oth;
      logic [W-1:0] d_e;
      @(negedge clk);
      policy = pol; req = rq; empty = em; full = fu;
      for (int p = 0; p < N; p++) rdata[p*W +: W] = $urandom;
      #1;
      g_e = (m_owned && !m_dead) ? (N'(1) << m_owner) : '0;
      for (int p = 0; p < N; p++) rdy[p] = OUTM[p] ? !fu[p] : !em[p];
      x_e = g_e & rq & rdy;
      d_e = rdata[m_owner*W +: W];
      check(grant === g_e, "R1/R4/R5/R11 grant", 64'(grant), 64'(g_e));
      check(xfer === x_e, "R2/R6/R7/R8 xfer", 64'(xfer), 64'(x_e));
      check(dead === m_dead, "R3/R12 dead", 64'(dead), 64'(m_dead));
      check(rd_valid === |(x_e & ~OUTM), "R10 rd_valid", 64'(rd_valid), 64'(|(x_e & ~OUTM)));
      check(wr_take === |(x_e & OUTM), "R10 wr_take", 64'(wr_take), 64'(|(x_e & OUTM)));
      if (|(x_e & ~OUTM)) check(rd_data === d_e, "R10 rd_data", 64'(rd_data), 64'(d_e));
      if (|xfer) moved++;
      // advance reference
      oth = rq & ~(N'(1) << m_owner);
      if (m_dead) m_dead = 0;
      else if (m_owned) begin
         if (|oth && (m_pol == 0 || !x_e[m_owner])) begin
            m_owner = first_from(oth, (m_owner + 1) % N);
            m_dead = 1;
         end else if (!rq[m_owner]) m_owned = 0;
      end else begin
         m_pol = pol;
         if (|rq) begin
            m_owner = first_from(rq, (m_owner + 1) % N);
            m_owned = 1;
         end
      end
   endtask

   initial begin
      logic [N-1:0] rq, em, fu;
      logic pol;
      int dens;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      #1;
      check(grant === '0, "R11 reset grant", 64'(grant), 0);
      check(xfer === '0, "R11 reset xfer", 64'(xfer), 0);
      check(dead === 1'b0, "R11 reset dead", 64'(dead), 0);
      rst_n = 1'b1;

      // R2: lone requester streams every cycle after the grant
      moved = 0;
      repeat (10) step(0, 4'b0001, '0, '0);
      check(moved == 9, "R2 lone stream count", moved, 9);
      repeat (3) step(0, '0, '0, '0);

      // R4: rotate with all requesting -> one word every two cycles
      moved = 0;
      repeat (40) step(0, 4'b1111, '0, '0);
      check(moved == 20, "R4 rotate count", moved, 20);
      repeat (3) step(1, '0, '0, '0);

      // R5 + R9: hold latched at idle, later policy flip ignored
      moved = 0;
      step(1, 4'b1111, '0, '0);
      repeat (39) step(0, 4'b1111, '0, '0);
      check(moved == 39, "R5/R9 hold count", moved, 39);
      repeat (3) step(0, '0, '0, '0);

      // R6/R7/R8: owner blocked by its flag while others wait
      repeat (6) step(1, 4'b0101, 4'b0001, 4'b1111);
      repeat (6) step(1, 4'b1100, 4'b1111, 4'b0100);
      repeat (3) step(0, '0, '0, '0);

      // mixed random traffic
      rq = '0; pol = 0; dens = 4;
      for (int c = 0; c < 4000; c++) begin
         if (c % 250 == 0) dens = 2 + ($urandom % 12);
         if ($urandom % 40 == 0) pol = ~pol;
         for (int p = 0; p < N; p++) if ($urandom % dens == 0) rq[p] = ~rq[p];
         em = '0; fu = '0;
         for (int p = 0; p < N; p++) begin
            em[p] = ($urandom % 6 == 0);
            fu[p] = ($urandom % 6 == 0);
         end
         step(pol, rq, em, fu);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule